// File: doc/BRIEF.md
# Multichannel Wilkinson Conversion Back End

This block is the digital half of a ramp-based multichannel converter. One Gray-coded counter runs at the conversion clock while an external analog ramp rises. Every channel has a comparator output, fed to the `hit` bus, which goes high when the ramp passes that channel's held voltage. On the first rising edge of its hit, the channel stores the counter value it sees at that moment. Because the counter is Gray-coded, a capture taken while the counter is changing is wrong by at most one code.

A low level on `start_n` starts a conversion from idle. The block then drives `ramp_start` and runs the counter from code 0. When the counter has used its whole range, the block raises `cnt_ovf`, stops the ramp and streams every stored result on `ser_data`, with `data_valid` high for the whole frame. A low level on `clr_n` clears the ramp and the counter at any time and returns the block to idle. The reset input `rst_n` acts asynchronously and is released on the clock. With the default parameters there are 64 channels of 12 bits, and the counter clock is 40 MHz.

Top module: `wk_adc_backend`

## Requirements
- R1: While reset is held, and after it is released, `ramp_reset`=1, `ramp_start`=0, `cnt_ovf`=0, `data_valid`=0 and `ser_data`=0.
- R2: `start_n` sampled low in idle starts a conversion. From the next cycle `ramp_start`=1, `ramp_reset`=0 and `cnt_ovf`=0, and the counter holds binary value k in conversion cycle k, counting from 0.
- R3: A conversion lasts exactly 2^W counter cycles (codes 0 to 2^W-1). In the following cycle `cnt_ovf`=1 and `ramp_start`=0. During counting, successive Gray codes differ in at most one bit.
- R4: A hit that rises in conversion cycle k passes through a two-flop synchronizer. The channel stores code k+2, limited to 2^W-1, and reports it as plain binary.
- R5: Only the first rising hit edge of a conversion is stored. A later fall and rise of the same hit has no effect on the result.
- R6: A channel with no rising hit edge inside the conversion window reports all ones (4095 at W=12). This includes a hit that was already high before the start.
- R7: The cycle after the conversion ends, `data_valid` rises and stays high for exactly N*W cycles. During those cycles `ser_data` carries channel 0 first, then channel 1 and so on, each word MSB first. After the frame `data_valid`=0 and the block is idle (`ramp_reset`=1).
- R8: `start_n` low during the readout frame is ignored. The frame continues unchanged and no new conversion starts.
- R9: `clr_n` sampled low returns the block to idle in the next cycle (`ramp_start`=0, `ramp_reset`=1, `cnt_ovf`=0). No frame is produced for the aborted conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_n | input | 1 | Active-low start of conversion |
| clr_n | input | 1 | Active-low clear of ramp and counter |
| hit | input | N_CH | Per-channel comparator outputs |
| ramp_start | output | 1 | Ramp generator run |
| ramp_reset | output | 1 | Ramp generator reset |
| cnt_ovf | output | 1 | Counter range exhausted, held until the next start or clear |
| ser_data | output | 1 | Serial result data |
| data_valid | output | 1 | High for the whole result frame |

## Verification
The assertions assume that `start_n` and `clr_n` are synchronous to `clk`, with low levels of at least one cycle. `hit` may change at any time, since it passes through the synchronizers. The bench changes every input on the falling clock edge and pulses the controls for single cycles. Hits are raised in known conversion cycles, so every stored code is known in advance. Pre-raised hits, a one-cycle pulse, a re-triggered hit and hits near the last code cover the edge-detection corners.

// File: rtl/wk_pkg.sv
package wk_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CONV = 2'd1,
    ST_READ = 2'd2
  } wk_state_e;

endpackage

// File: rtl/wk_gray_counter.sv
module wk_gray_counter #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  output logic [W-1:0] gray_q,
  output logic         at_top
);

  logic [W-1:0] bin_q, bin_d, gray_d;

  always_comb begin
    bin_d = bin_q;
    if (clr)     bin_d = '0;
    else if (en) bin_d = bin_q + 1'b1;
    gray_d = bin_d ^ (bin_d >> 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bin_q  <= '0;
      gray_q <= '0;
    end else begin
      bin_q  <= bin_d;
      gray_q <= gray_d;
    end
  end

  assign at_top = &bin_q;

endmodule

// File: rtl/wk_capture_bank.sv
module wk_capture_bank #(
  parameter int N_CH = 64,
  parameter int W    = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_CH-1:0]   hit,
  input  logic              arm,
  input  logic              window,
  input  logic [W-1:0]      gray_in,
  output logic [N_CH*W-1:0] codes_flat
);

  // Gray image of the all-ones binary code: MSB set, rest clear
  localparam logic [W-1:0] FULL_GRAY = {1'b1, {(W-1){1'b0}}};

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    logic         s1_q, s2_q, s3_q;
    logic         armed_q, armed_d;
    logic [W-1:0] code_q, code_d;
    logic         rise;

    assign rise = s2_q & ~s3_q;

    always_comb begin
      armed_d = armed_q;
      code_d  = code_q;
      if (arm) begin
        armed_d = 1'b1;
        code_d  = FULL_GRAY;
      end else if (window && armed_q && rise) begin
        armed_d = 1'b0;
        code_d  = gray_in;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q    <= 1'b0;
        s2_q    <= 1'b0;
        s3_q    <= 1'b0;
        armed_q <= 1'b0;
        code_q  <= FULL_GRAY;
      end else begin
        s1_q    <= hit[c];
        s2_q    <= s1_q;
        s3_q    <= s2_q;
        armed_q <= armed_d;
        code_q  <= code_d;
      end
    end

    assign codes_flat[c*W +: W] = code_q;
  end

endmodule

// File: rtl/wk_serializer.sv
module wk_serializer #(
  parameter int N_CH = 64,
  parameter int W    = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              abort,
  input  logic [N_CH*W-1:0] codes_flat,
  output logic              sdo,
  output logic              active,
  output logic              last_bit
);

  localparam int CHW = (N_CH > 1) ? $clog2(N_CH) : 1;
  localparam int BW  = (W > 1) ? $clog2(W) : 1;
  localparam logic [CHW-1:0] CH_LAST  = CHW'(N_CH - 1);
  localparam logic [BW-1:0]  BIT_LAST = BW'(W - 1);

  function automatic logic [W-1:0] gray_to_bin(input logic [W-1:0] g);
    logic [W-1:0] b;
    b[W-1] = g[W-1];
    for (int i = W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic           act_q, act_d;
  logic [CHW-1:0] ch_q, ch_d, ch_inc;
  logic [BW-1:0]  bit_q, bit_d;
  logic [W-1:0]   sh_q, sh_d;
  logic [W-1:0]   word_first, word_next;

  assign ch_inc     = ch_q + 1'b1;
  assign word_first = codes_flat[0 +: W];
  assign word_next  = codes_flat[ch_inc*W +: W];

  always_comb begin
    act_d = act_q;
    ch_d  = ch_q;
    bit_d = bit_q;
    sh_d  = sh_q;
    if (abort) begin
      act_d = 1'b0;
    end else if (load) begin
      act_d = 1'b1;
      ch_d  = '0;
      bit_d = '0;
      sh_d  = gray_to_bin(word_first);
    end else if (act_q) begin
      if (bit_q == BIT_LAST) begin
        if (ch_q == CH_LAST) begin
          act_d = 1'b0;
        end else begin
          ch_d  = ch_inc;
          bit_d = '0;
          sh_d  = gray_to_bin(word_next);
        end
      end else begin
        bit_d = bit_q + 1'b1;
        sh_d  = sh_q << 1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      ch_q  <= '0;
      bit_q <= '0;
      sh_q  <= '0;
    end else begin
      act_q <= act_d;
      ch_q  <= ch_d;
      bit_q <= bit_d;
      sh_q  <= sh_d;
    end
  end

  assign sdo      = act_q & sh_q[W-1];
  assign active   = act_q;
  assign last_bit = act_q && (bit_q == BIT_LAST) && (ch_q == CH_LAST);

endmodule

// File: rtl/wk_adc_backend.sv
module wk_adc_backend
  import wk_pkg::*;
#(
  parameter int N_CH = 64,
  parameter int W    = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_n,
  input  logic            clr_n,
  input  logic [N_CH-1:0] hit,
  output logic            ramp_start,
  output logic            ramp_reset,
  output logic            cnt_ovf,
  output logic            ser_data,
  output logic            data_valid
);

  localparam int FLAT_W = N_CH * W;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       core_rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  wk_state_e         state_q, state_d;
  logic              ovf_q, ovf_d;
  logic              cnt_clr, cnt_en, cnt_top;
  logic              arm, ser_load, ser_abort, ser_active, ser_last;
  logic [W-1:0]      gray_cnt;
  logic [FLAT_W-1:0] codes_flat;

  always_comb begin
    state_d   = state_q;
    ovf_d     = ovf_q;
    cnt_clr   = 1'b0;
    cnt_en    = 1'b0;
    arm       = 1'b0;
    ser_load  = 1'b0;
    ser_abort = 1'b0;
    if (!clr_n) begin
      state_d   = ST_IDLE;
      ovf_d     = 1'b0;
      cnt_clr   = 1'b1;
      ser_abort = 1'b1;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          cnt_clr = 1'b1;
          if (!start_n) begin
            state_d = ST_CONV;
            ovf_d   = 1'b0;
            arm     = 1'b1;
          end
        end
        ST_CONV: begin
          if (cnt_top) begin
            state_d  = ST_READ;
            ovf_d    = 1'b1;
            ser_load = 1'b1;
          end else begin
            cnt_en = 1'b1;
          end
        end
        ST_READ: begin
          if (ser_last) state_d = ST_IDLE;
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      state_q <= ST_IDLE;
      ovf_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      ovf_q   <= ovf_d;
    end
  end

  wk_gray_counter #(.W(W)) u_cnt (
    .clk    (clk),
    .rst_n  (core_rst_n),
    .clr    (cnt_clr),
    .en     (cnt_en),
    .gray_q (gray_cnt),
    .at_top (cnt_top)
  );

  wk_capture_bank #(.N_CH(N_CH), .W(W)) u_cap (
    .clk        (clk),
    .rst_n      (core_rst_n),
    .hit        (hit),
    .arm        (arm),
    .window     (state_q == ST_CONV),
    .gray_in    (gray_cnt),
    .codes_flat (codes_flat)
  );

  wk_serializer #(.N_CH(N_CH), .W(W)) u_ser (
    .clk        (clk),
    .rst_n      (core_rst_n),
    .load       (ser_load),
    .abort      (ser_abort),
    .codes_flat (codes_flat),
    .sdo        (ser_data),
    .active     (ser_active),
    .last_bit   (ser_last)
  );

  assign ramp_start = (state_q == ST_CONV);
  assign ramp_reset = (state_q == ST_IDLE);
  assign cnt_ovf    = ovf_q;
  assign data_valid = ser_active;

endmodule

// File: rtl/wk_adc_backend_chk.sv
module wk_adc_backend_chk #(
  parameter int W = 12
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start_n,
  input logic         clr_n,
  input logic         ramp_start,
  input logic         ramp_reset,
  input logic         cnt_ovf,
  input logic         data_valid,
  input logic [W-1:0] gray_cnt
);

  a_r2_ramp_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(ramp_start && ramp_reset));

  a_r3_gray_one_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (ramp_start && $past(ramp_start)) |-> ($countones(gray_cnt ^ $past(gray_cnt)) <= 1));

  a_r3_ovf_ends_ramp: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cnt_ovf) |-> (!ramp_start && data_valid));

  a_r7_no_frame_while_ramp: assert property (@(posedge clk) disable iff (!rst_n)
    !(data_valid && ramp_start));

  a_r8_start_ignored_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (data_valid && !start_n && clr_n) |=> !ramp_start);

  a_r9_clear_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |=> (ramp_reset && !data_valid && !cnt_ovf));

endmodule

bind wk_adc_backend wk_adc_backend_chk #(.W(W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_n    (start_n),
  .clr_n      (clr_n),
  .ramp_start (ramp_start),
  .ramp_reset (ramp_reset),
  .cnt_ovf    (cnt_ovf),
  .data_valid (data_valid),
  .gray_cnt   (gray_cnt)
);

// File: tb/wk_adc_backend_tb_top.sv
module wk_adc_backend_tb_top;
  localparam int N     = 64;
  localparam int W     = 12;
  localparam int MAXC  = (1 << W) - 1;
  localparam int FRAME = N * W;

  // table: {first hit cycle, spacing between channels, pre-high every Nth channel (0 = none)}
  localparam logic [39:0] VEC [4] = '{
    {16'd0,    16'd1,  8'd0},
    {16'd100,  16'd63, 8'd0},
    {16'd4000, 16'd2,  8'd0},
    {16'd7,    16'd31, 8'd3}
  };

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic         rst_n, start_n, clr_n;
  logic [N-1:0] hit;
  logic         ramp_start, ramp_reset, cnt_ovf, ser_data, data_valid;

  wk_adc_backend #(.N_CH(N), .W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_n(start_n), .clr_n(clr_n), .hit(hit),
    .ramp_start(ramp_start), .ramp_reset(ramp_reset), .cnt_ovf(cnt_ovf),
    .ser_data(ser_data), .data_valid(data_valid)
  );

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  int hit_t[N], hit_lo[N], hit_re[N], exp_code[N], got[N];
  bit pre[N];

  always @(posedge clk) cyc++;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    wait (cyc >= 190000);
    errors++;
    $display("FAIL R7 watchdog expired actual=%0d expected=%0d", cyc, 190000);
    finish_run();
  end

  task automatic clear_plan;
    for (int c = 0; c < N; c++) begin
      hit_t[c] = -1; hit_lo[c] = -1; hit_re[c] = -1; pre[c] = 1'b0;
    end
  endtask

  // R4/R6: first edge in cycle t stores t+2, limited to full scale; none gives full scale
  task automatic compute_exp;
    for (int c = 0; c < N; c++) begin
      if (pre[c] || hit_t[c] < 0) exp_code[c] = MAXC;
      else if (hit_t[c] + 2 > MAXC) exp_code[c] = MAXC;
      else exp_code[c] = hit_t[c] + 2;
    end
  endtask

  task automatic run_conv(input bit poke_start, input string name);
    bit dv_bad;
    dv_bad = 1'b0;
    for (int c = 0; c < N; c++) begin
      hit[c] = pre[c];
      got[c] = 0;
    end
    repeat (4) @(negedge clk);
    start_n = 1'b0;
    @(negedge clk);
    start_n = 1'b1;
    chk(ramp_start && !ramp_reset && !cnt_ovf, {"R2 ramp started ", name}, ramp_start, 1);
    for (int k = 0; k <= MAXC; k++) begin
      if (k > 0) @(negedge clk);
      if (k == MAXC)
        chk(ramp_start && !data_valid && !cnt_ovf, {"R3 still counting at last code ", name}, ramp_start, 1);
      for (int c = 0; c < N; c++) begin
        if (hit_t[c] == k)  hit[c] = 1'b1;
        if (hit_lo[c] == k) hit[c] = 1'b0;
        if (hit_re[c] == k) hit[c] = 1'b1;
      end
    end
    @(negedge clk);
    chk(cnt_ovf && !ramp_start && data_valid, {"R3 overflow ends ramp ", name}, cnt_ovf, 1);
    for (int j = 0; j < FRAME; j++) begin
      if (j > 0) @(negedge clk);
      if (!data_valid) dv_bad = 1'b1;
      got[j / W] = (got[j / W] << 1) | int'(ser_data);
      if (poke_start && j == 300) start_n = 1'b0;
      if (poke_start && j == 301) start_n = 1'b1;
    end
    @(negedge clk);
    chk(!data_valid && ramp_reset && !ramp_start, {"R7 frame length and idle after ", name}, data_valid, 0);
    chk(!dv_bad, {"R7 data_valid held over frame ", name}, dv_bad, 0);
    if (poke_start)
      chk(!ramp_start && ramp_reset, {"R8 no restart after start in frame ", name}, ramp_start, 0);
    for (int c = 0; c < N; c++)
      chk(got[c] == exp_code[c], $sformatf("R4 R6 R7 %s ch%0d", name, c), got[c], exp_code[c]);
    hit = '0;
  endtask

  initial begin
    rst_n = 1'b0; start_n = 1'b1; clr_n = 1'b1; hit = '0;
    repeat (3) @(negedge clk);
    chk(ramp_reset && !ramp_start && !data_valid && !cnt_ovf && !ser_data, "R1 state in reset", ramp_start, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(ramp_reset && !ramp_start && !data_valid && !cnt_ovf && !ser_data, "R1 state after reset", data_valid, 0);

    // table of hit patterns
    for (int v = 0; v < 4; v++) begin
      int base, stride, every;
      base   = int'(VEC[v][39:24]);
      stride = int'(VEC[v][23:8]);
      every  = int'(VEC[v][7:0]);
      clear_plan();
      for (int c = 0; c < N; c++) begin
        if (every != 0 && (c % every) == 0) pre[c] = 1'b1;
        else hit_t[c] = base + stride * c;
      end
      compute_exp();
      run_conv(1'b0, $sformatf("vec%0d", v));
    end

    // R5 re-trigger, one-cycle pulse, boundary codes; R8 start during frame
    clear_plan();
    hit_t[5] = 10;    hit_lo[5] = 20;  hit_re[5] = 50;
    hit_t[0] = 300;   hit_lo[0] = 301;
    hit_t[62] = 4092;
    hit_t[63] = 4093;
    compute_exp();
    run_conv(1'b1, "R5 first edge only");

    // R9 clear aborts a conversion
    begin
      bit saw_dv;
      saw_dv = 1'b0;
      hit = '0;
      start_n = 1'b0;
      @(negedge clk);
      start_n = 1'b1;
      repeat (500) @(negedge clk);
      chk(ramp_start, "R9 conversion running before clear", ramp_start, 1);
      clr_n = 1'b0;
      @(negedge clk);
      clr_n = 1'b1;
      chk(!ramp_start && ramp_reset && !cnt_ovf, "R9 idle after clear", ramp_start, 0);
      for (int i = 0; i < 4300; i++) begin
        @(negedge clk);
        if (data_valid || cnt_ovf || ramp_start) saw_dv = 1'b1;
      end
      chk(!saw_dv, "R9 no frame after clear", saw_dv, 0);
    end

    finish_run();
  end

endmodule